// File: doc/BRIEF.md
# JTAG In-System Programming Command Sequencer

This block is the programming controller behind a four-wire serial test port. It contains the full sixteen-state test-port controller driven by TMS on the rising edge of the test clock (the `clk` input). It also holds a four-bit instruction register and a small set of data registers: identification, one-bit bypass, column address and column data. A model of the non-volatile logic array holds two halves of columns. The lower half is the product-term array and the upper half is the architecture array.

Host software works in a fixed order. It loads the programming-enable instruction, scans in a column address, and scans in column data. It then loads an erase, program or fuse instruction and lets the port idle in Run-Test-Idle. The action takes place on the second rising clock edge spent in that state. Each action is reported by a one-cycle strobe. A completed erase, program or fuse action leaves a high-voltage flag set. A discharge instruction clears that flag before any column can be read back. While any device-specific instruction is active, a safe-state output tells the rest of the chip to park its outputs.

Top module: `isp_seq_top`

## Requirements
- R1: After reset and whenever the port controller is in Test-Logic-Reset, the active instruction becomes IDCODE (opcode 4'h1). A data scan then returns the 32-bit code LSB first: bit 0 = 1, bits 11:1 = manufacturer parameter, bits 27:12 = 16'h0141, bits 31:28 = version parameter.
- R2: Opcodes with no assigned function (4'h0, 4'hB to 4'hE), BYPASS (4'hF) and the non-scan opcodes 4'h2, 4'h5 to 4'h8 and 4'hA select a one-bit bypass register. It captures 0, so a two-bit scan of 1,1 returns 0 then 1.
- R3: `safe_state` is high exactly while the active instruction is one of ADDRESS 4'h3, DATA 4'h4, ERASE_PT 4'h5, ERASE_ARCH 4'h6, PROG_COL 4'h7, PROG_FUSE 4'h8, READ_COL 4'h9 or DISCHARGE 4'hA. It is low for IDCODE, PROG_EN 4'h2 and all other opcodes.
- R4: ADDRESS selects a 3-bit column address, shifted LSB first. Its MSB selects the architecture half (1) or the product-term half (0). A scan returns the previous address.
- R5: DATA selects an 8-bit column data register, shifted LSB first. A scan returns the contents left by the previous scan.
- R6: ERASE_PT, ERASE_ARCH, PROG_COL and PROG_FUSE act on the second rising edge spent in Run-Test-Idle. The matching strobe is high for the one cycle after that edge, and fires at most once per visit to Run-Test-Idle.
- R7: Erase, program and fuse instructions do nothing unless PROG_EN has been loaded since the last reset or Test-Logic-Reset.
- R8: ERASE_PT clears every column whose address MSB is 0. ERASE_ARCH clears every column whose address MSB is 1. PROG_COL writes the data register into the addressed column.
- R9: Each erase, program or fuse action sets a high-voltage flag. DISCHARGE needs no programming mode. It fires on the second Run-Test-Idle edge, pulses its strobe and clears the flag.
- R10: In Capture-DR with READ_COL active, the addressed column is loaded into the data register and the read strobe pulses one cycle later. This happens only if the high-voltage flag is clear and the fuse is intact. Otherwise zero is loaded and there is no strobe.
- R11: After a PROG_FUSE action, every read returns zero.
- R12: `tdo` shows bit 0 of the instruction register in Shift-IR and bit 0 of the selected data register in Shift-DR; it is 0 in every other state. Capture-IR loads 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| safe_state | output | 1 | Request to park device outputs |
| stb_erase_pt | output | 1 | Product-term bulk erase strobe |
| stb_erase_arch | output | 1 | Architecture bulk erase strobe |
| stb_prog_col | output | 1 | Column program strobe |
| stb_prog_fuse | output | 1 | Security fuse program strobe |
| stb_read_col | output | 1 | Column read strobe |
| stb_discharge | output | 1 | Supply discharge strobe |

## Verification
Once the port reaches Run-Test-Idle, an action strobe is due in the cycle after the second idle edge. The bench counts idle clocks from zero and expects the strobe exactly at index 1 and nowhere else in a window of several clocks. A read strobe is due one cycle after Capture-DR, which is the first shift cycle of the scan. The bench samples `tdo` at each falling edge before the shifting edge, so bit i of a scan is the captured bit i. `safe_state` follows Update-IR after one edge, and the bench reads it once the scan has returned to idle.

// File: rtl/isp_seq_pkg.sv
package isp_seq_pkg;

    localparam int IR_W = 4;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
    localparam logic [15:0] PART_NUMBER = 16'h0141;

    typedef enum logic [3:0] {
        TLR, RTI, SEL_DR, CAP_DR, SHIFT_DR, EXIT1_DR, PAUSE_DR, EXIT2_DR, UPD_DR,
        SEL_IR, CAP_IR, SHIFT_IR, EXIT1_IR, PAUSE_IR, EXIT2_IR, UPD_IR
    } tap_state_e;

    typedef enum logic [IR_W-1:0] {
        OP_IDCODE     = 4'h1,
        OP_PROG_EN    = 4'h2,
        OP_ADDR       = 4'h3,
        OP_DATA       = 4'h4,
        OP_ERASE_PT   = 4'h5,
        OP_ERASE_ARCH = 4'h6,
        OP_PROG_COL   = 4'h7,
        OP_PROG_FUSE  = 4'h8,
        OP_READ_COL   = 4'h9,
        OP_DISCHARGE  = 4'hA,
        OP_BYPASS     = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {DR_BYPASS, DR_IDCODE, DR_ADDR, DR_DATA} dr_sel_e;

    typedef struct packed {
        logic erase_pt;
        logic erase_arch;
        logic prog_col;
        logic prog_fuse;
        logic read_col;
        logic discharge;
    } strobe_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        case (s)
            TLR:      return tms ? TLR      : RTI;
            RTI:      return tms ? SEL_DR   : RTI;
            SEL_DR:   return tms ? SEL_IR   : CAP_DR;
            CAP_DR:   return tms ? EXIT1_DR : SHIFT_DR;
            SHIFT_DR: return tms ? EXIT1_DR : SHIFT_DR;
            EXIT1_DR: return tms ? UPD_DR   : PAUSE_DR;
            PAUSE_DR: return tms ? EXIT2_DR : PAUSE_DR;
            EXIT2_DR: return tms ? UPD_DR   : SHIFT_DR;
            UPD_DR:   return tms ? SEL_DR   : RTI;
            SEL_IR:   return tms ? TLR      : CAP_IR;
            CAP_IR:   return tms ? EXIT1_IR : SHIFT_IR;
            SHIFT_IR: return tms ? EXIT1_IR : SHIFT_IR;
            EXIT1_IR: return tms ? UPD_IR   : PAUSE_IR;
            PAUSE_IR: return tms ? EXIT2_IR : PAUSE_IR;
            EXIT2_IR: return tms ? UPD_IR   : SHIFT_IR;
            UPD_IR:   return tms ? SEL_DR   : RTI;
            default:  return TLR;
        endcase
    endfunction

    function automatic logic is_private(logic [IR_W-1:0] op);
        return (op >= OP_ADDR) && (op <= OP_DISCHARGE);
    endfunction

    function automatic dr_sel_e decode_dr(logic [IR_W-1:0] op);
        case (op)
            OP_IDCODE:             return DR_IDCODE;
            OP_ADDR:               return DR_ADDR;
            OP_DATA, OP_READ_COL:  return DR_DATA;
            default:               return DR_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/isp_tap_fsm.sv
module isp_tap_fsm
    import isp_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge clk) begin
        if (rst) state <= TLR;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/isp_instr_reg.sv
module isp_instr_reg
    import isp_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_q,
    output logic            prog_mode,
    output logic            ir_tdo
);
    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_sh     <= IR_CAPTURE;
            ir_q      <= OP_IDCODE;
            prog_mode <= 1'b0;
        end else begin
            case (state)
                TLR: begin
                    ir_q      <= OP_IDCODE;
                    prog_mode <= 1'b0;
                end
                CAP_IR:   ir_sh <= IR_CAPTURE;
                SHIFT_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                UPD_IR: begin
                    ir_q <= ir_sh;
                    if (ir_sh == OP_PROG_EN) prog_mode <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ir_tdo = ir_sh[0];
endmodule

// File: rtl/isp_dr_bank.sv
module isp_dr_bank
    import isp_seq_pkg::*;
#(
    parameter int          ADDR_W   = 3,
    parameter int          DW       = 8,
    parameter logic [31:0] ID_VALUE = 32'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  tap_state_e        state,
    input  logic [IR_W-1:0]   ir_q,
    input  logic              tdi,
    input  logic [DW-1:0]     cap_data,
    output logic [ADDR_W-1:0] col_addr,
    output logic [DW-1:0]     data_q,
    output logic              dr_tdo
);
    dr_sel_e     sel;
    logic        bypass_q;
    logic [31:0] id_sh;

    assign sel = decode_dr(ir_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            bypass_q <= 1'b0;
            id_sh    <= ID_VALUE;
            col_addr <= '0;
            data_q   <= '0;
        end else if (state == CAP_DR) begin
            case (sel)
                DR_BYPASS: bypass_q <= 1'b0;
                DR_IDCODE: id_sh    <= ID_VALUE;
                DR_DATA:   if (ir_q == OP_READ_COL) data_q <= cap_data;
                default: ;
            endcase
        end else if (state == SHIFT_DR) begin
            case (sel)
                DR_BYPASS: bypass_q <= tdi;
                DR_IDCODE: id_sh    <= {tdi, id_sh[31:1]};
                DR_ADDR:   col_addr <= {tdi, col_addr[ADDR_W-1:1]};
                DR_DATA:   data_q   <= {tdi, data_q[DW-1:1]};
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            DR_IDCODE: dr_tdo = id_sh[0];
            DR_ADDR:   dr_tdo = col_addr[0];
            DR_DATA:   dr_tdo = data_q[0];
            default:   dr_tdo = bypass_q;
        endcase
    end
endmodule

// File: rtl/isp_action_ctrl.sv
module isp_action_ctrl
    import isp_seq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  tap_state_e        state,
    input  logic [IR_W-1:0]   ir_q,
    input  logic              prog_mode,
    input  logic [ADDR_W-1:0] col_addr,
    input  logic [DW-1:0]     data_q,
    output logic [DW-1:0]     cap_data,
    output logic              hv_active,
    output strobe_t           stb
);
    localparam int NCOL = 2 ** ADDR_W;

    logic [1:0]               rti_cnt;
    logic                     fuse_q;
    logic                     fire;
    logic                     go_erase_pt, go_erase_arch, go_prog, go_fuse, go_dis, go_read;
    logic                     rd_ok;
    logic [NCOL-1:0][DW-1:0]  col_bus;

    assign fire          = (state == RTI) && (rti_cnt == 2'd1);
    assign go_erase_pt   = fire && prog_mode && (ir_q == OP_ERASE_PT);
    assign go_erase_arch = fire && prog_mode && (ir_q == OP_ERASE_ARCH);
    assign go_prog       = fire && prog_mode && (ir_q == OP_PROG_COL);
    assign go_fuse       = fire && prog_mode && (ir_q == OP_PROG_FUSE);
    assign go_dis        = fire && (ir_q == OP_DISCHARGE);
    assign rd_ok         = !hv_active && !fuse_q;
    assign go_read       = (state == CAP_DR) && (ir_q == OP_READ_COL) && rd_ok;
    assign cap_data      = rd_ok ? col_bus[col_addr] : '0;

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(c);
        logic [DW-1:0] col_q;
        always_ff @(posedge clk) begin
            if (rst)
                col_q <= '0;
            else if ((go_erase_pt && !IDX[ADDR_W-1]) || (go_erase_arch && IDX[ADDR_W-1]))
                col_q <= '0;
            else if (go_prog && (col_addr == IDX))
                col_q <= data_q;
        end
        assign col_bus[c] = col_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rti_cnt   <= '0;
            fuse_q    <= 1'b0;
            hv_active <= 1'b0;
            stb       <= '0;
        end else begin
            if (state != RTI)          rti_cnt <= '0;
            else if (rti_cnt != 2'd2)  rti_cnt <= rti_cnt + 2'd1;
            if (go_fuse) fuse_q <= 1'b1;
            if (go_erase_pt || go_erase_arch || go_prog || go_fuse) hv_active <= 1'b1;
            else if (go_dis)                                        hv_active <= 1'b0;
            stb.erase_pt   <= go_erase_pt;
            stb.erase_arch <= go_erase_arch;
            stb.prog_col   <= go_prog;
            stb.prog_fuse  <= go_fuse;
            stb.read_col   <= go_read;
            stb.discharge  <= go_dis;
        end
    end
endmodule

// File: rtl/isp_seq_top.sv
module isp_seq_top
    import isp_seq_pkg::*;
#(
    parameter int          COL_AW   = 2,
    parameter int          DW       = 8,
    parameter logic [3:0]  VERSION  = 4'h3,
    parameter logic [10:0] MFR_CODE = 11'h055
) (
    input  logic clk,
    input  logic rst,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic safe_state,
    output logic stb_erase_pt,
    output logic stb_erase_arch,
    output logic stb_prog_col,
    output logic stb_prog_fuse,
    output logic stb_read_col,
    output logic stb_discharge
);
    localparam int          ADDR_W   = COL_AW + 1;
    localparam logic [31:0] ID_VALUE = {VERSION, PART_NUMBER, MFR_CODE, 1'b1};

    tap_state_e        tap_state;
    logic [IR_W-1:0]   ir_q;
    logic              prog_mode, ir_tdo, dr_tdo, hv_active;
    logic [ADDR_W-1:0] col_addr;
    logic [DW-1:0]     data_q, cap_data;
    strobe_t           stb;

    isp_tap_fsm u_tap (.clk(clk), .rst(rst), .tms(tms), .state(tap_state));

    isp_instr_reg u_ir (
        .clk(clk), .rst(rst), .state(tap_state), .tdi(tdi),
        .ir_q(ir_q), .prog_mode(prog_mode), .ir_tdo(ir_tdo)
    );

    isp_dr_bank #(.ADDR_W(ADDR_W), .DW(DW), .ID_VALUE(ID_VALUE)) u_dr (
        .clk(clk), .rst(rst), .state(tap_state), .ir_q(ir_q), .tdi(tdi),
        .cap_data(cap_data), .col_addr(col_addr), .data_q(data_q), .dr_tdo(dr_tdo)
    );

    isp_action_ctrl #(.ADDR_W(ADDR_W), .DW(DW)) u_act (
        .clk(clk), .rst(rst), .state(tap_state), .ir_q(ir_q), .prog_mode(prog_mode),
        .col_addr(col_addr), .data_q(data_q), .cap_data(cap_data),
        .hv_active(hv_active), .stb(stb)
    );

    always_comb begin
        case (tap_state)
            SHIFT_IR: tdo = ir_tdo;
            SHIFT_DR: tdo = dr_tdo;
            default:  tdo = 1'b0;
        endcase
    end

    assign safe_state     = is_private(ir_q);
    assign stb_erase_pt   = stb.erase_pt;
    assign stb_erase_arch = stb.erase_arch;
    assign stb_prog_col   = stb.prog_col;
    assign stb_prog_fuse  = stb.prog_fuse;
    assign stb_read_col   = stb.read_col;
    assign stb_discharge  = stb.discharge;
endmodule

// File: rtl/isp_seq_checker.sv
module isp_seq_checker
    import isp_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input tap_state_e      tap_state,
    input logic [IR_W-1:0] ir_q,
    input logic            prog_mode,
    input logic            hv_active,
    input logic            safe_state,
    input strobe_t         stb
);
    logic hv_strobe;
    assign hv_strobe = stb.erase_pt | stb.erase_arch | stb.prog_col | stb.prog_fuse;

    AST_TLR_IDCODE: assert property (@(posedge clk) disable iff (rst)
        (tap_state == TLR) |=> (ir_q == OP_IDCODE)); // R1
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb)); // R6
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (hv_strobe || stb.discharge) |=> !(hv_strobe || stb.discharge)); // R6
    AST_STROBE_FROM_RTI: assert property (@(posedge clk) disable iff (rst)
        (hv_strobe || stb.discharge) |-> ($past(tap_state) == RTI)); // R6
    AST_STROBE_SAFE: assert property (@(posedge clk) disable iff (rst)
        (hv_strobe || stb.discharge || stb.read_col) |-> safe_state); // R3
    AST_NEEDS_PROG_MODE: assert property (@(posedge clk) disable iff (rst)
        hv_strobe |-> prog_mode); // R7
    AST_ACTION_SETS_HV: assert property (@(posedge clk) disable iff (rst)
        hv_strobe |-> hv_active); // R9
    AST_DISCHARGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stb.discharge |-> !hv_active); // R9
    AST_READ_NO_HV: assert property (@(posedge clk) disable iff (rst)
        stb.read_col |-> !$past(hv_active)); // R10
endmodule

bind isp_seq_top isp_seq_checker u_chk (
    .clk(clk), .rst(rst), .tap_state(tap_state), .ir_q(ir_q), .prog_mode(prog_mode),
    .hv_active(hv_active), .safe_state(safe_state), .stb(stb)
);

// File: tb/isp_seq_top_test.sv
module isp_seq_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, safe_state;
    logic s_ept, s_earch, s_prog, s_fuse, s_read, s_dis;

    localparam logic [31:0] EXP_ID = {4'h3, 16'h0141, 11'h055, 1'b1};

    int n_checks = 0, n_fail = 0;
    int c_ept = 0, c_earch = 0, c_prog = 0, c_fuse = 0, c_read = 0, c_dis = 0;
    logic [2:0] exp_addr = '0;
    logic [7:0] exp_data = '0;
    logic [7:0] col_model [8];

    always #10 clk = ~clk;

    isp_seq_top uut (
        .clk(clk), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .safe_state(safe_state),
        .stb_erase_pt(s_ept), .stb_erase_arch(s_earch), .stb_prog_col(s_prog),
        .stb_prog_fuse(s_fuse), .stb_read_col(s_read), .stb_discharge(s_dis)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge clk); @(negedge clk);
        c_ept += s_ept; c_earch += s_earch; c_prog += s_prog;
        c_fuse += s_fuse; c_read += s_read; c_dis += s_dis;
    endtask

    task automatic go_reset_idle();
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic ir_scan(input logic [3:0] op, output logic [3:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) begin
            cap[i] = tdo;
            tick(i == 3, op[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic load(input logic [3:0] op);
        logic [3:0] unused;
        ir_scan(op, unused);
    endtask

    task automatic dr_scan(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            tick(i == n - 1, din[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    // idle n clocks in Run-Test-Idle; report index of first action strobe and count
    task automatic idle(input int n, output int first, output int cnt);
        first = -1; cnt = 0;
        for (int i = 0; i < n; i++) begin
            tick(0, 0);
            if (s_ept | s_earch | s_prog | s_fuse | s_dis) begin
                if (first < 0) first = i;
                cnt++;
            end
        end
    endtask

    task automatic set_addr(input logic [2:0] a);
        logic [31:0] o;
        load(4'h3);
        dr_scan(3, {29'b0, a}, o);
        check("R4 address scan-out", o, {29'b0, exp_addr});
        exp_addr = a;
    endtask

    task automatic set_data(input logic [7:0] d);
        logic [31:0] o;
        load(4'h4);
        dr_scan(8, {24'b0, d}, o);
        check("R5 data scan-out", o, {24'b0, exp_data});
        exp_data = d;
    endtask

    task automatic read_col(input string req, input logic [7:0] exp, input logic exp_stb);
        logic [31:0] o;
        int r0;
        load(4'h9);
        r0 = c_read;
        dr_scan(8, 32'h0, o);
        check({req, " read value"}, o, {24'b0, exp});
        check({req, " read strobe"}, c_read - r0, {31'b0, exp_stb});
        exp_data = 8'h00;
    endtask

    task automatic run_action(input string req, input logic [3:0] op, input int exp_first,
                              input int exp_cnt);
        int f, k;
        load(op);
        idle(6, f, k);
        check({req, " strobe index"}, f, exp_first);
        check({req, " strobe count"}, k, exp_cnt);
    endtask

    initial begin : watchdog
        #3000000;
        n_fail++; n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] o;
        logic [3:0] cap;
        int f, k, p0;
        for (int c = 0; c < 8; c++) col_model[c] = 8'h00;

        tick(1, 0); tick(1, 0);
        rst = 1'b0;
        check("R3 safe_state at reset", safe_state, 0);
        check("R12 tdo in reset state", tdo, 0);
        tick(0, 0);
        dr_scan(32, 32'h0, o);
        check("R1 IDCODE after reset", o, EXP_ID);
        check("R12 tdo in idle", tdo, 0);
        ir_scan(4'h1, cap);
        check("R12 IR capture pattern", cap, 4'b0001);

        // sweep every opcode
        for (int op = 0; op < 16; op++) begin
            logic [3:0] opv;
            opv = 4'(op);
            load(opv);
            check("R3 safe_state per opcode", safe_state, (op >= 3 && op <= 10) ? 1 : 0);
            if (op == 1) begin
                dr_scan(32, 32'h0, o);
                check("R1 IDCODE opcode", o, EXP_ID);
            end else if (op != 3 && op != 4 && op != 9) begin
                dr_scan(2, 32'h3, o);
                check("R2 bypass scan", o, 32'h2);
            end
        end

        // leave via Test-Logic-Reset with DATA loaded
        load(4'h4);
        go_reset_idle();
        check("R3 safe_state after TLR", safe_state, 0);
        dr_scan(32, 32'h0, o);
        check("R1 IDCODE after TLR", o, EXP_ID);

        // program without programming mode
        set_addr(3'd2);
        set_data(8'hA5);
        run_action("R7 program ignored", 4'h7, -1, 0);
        read_col("R7", 8'h00, 1);

        // program / read every column
        load(4'h2);
        for (int c = 0; c < 8; c++) begin
            logic [7:0] v;
            v = 8'(c * 37 + 11);
            set_addr(3'(c));
            set_data(v);
            p0 = c_prog;
            run_action("R6 program", 4'h7, 1, 1);
            check("R6 program strobe port", c_prog - p0, 1);
            col_model[c] = v;
            if (c == 0) begin
                dr_scan(2, 32'h0, o);
                idle(6, f, k);
                check("R6 second visit strobe", k, 1);
            end
            read_col("R9 blocked by high voltage", 8'h00, 0);
            run_action("R9 discharge", 4'hA, 1, 1);
            set_addr(3'(c));
            read_col("R8 program", v, 1);
        end

        // bulk erase of each half
        run_action("R6 erase product-term", 4'h5, 1, 1);
        run_action("R9 discharge", 4'hA, 1, 1);
        for (int c = 0; c < 8; c++) begin
            set_addr(3'(c));
            read_col("R8 after product-term erase", (c < 4) ? 8'h00 : col_model[c], 1);
        end
        run_action("R6 erase architecture", 4'hA - 4'h4, 1, 1);
        run_action("R9 discharge", 4'hA, 1, 1);
        for (int c = 4; c < 8; c++) begin
            set_addr(3'(c));
            read_col("R8 after architecture erase", 8'h00, 1);
        end

        // programming mode cleared by Test-Logic-Reset
        go_reset_idle();
        exp_data = exp_data;
        set_addr(3'd1);
        set_data(8'h3C);
        run_action("R7 program after TLR", 4'h7, -1, 0);
        run_action("R7 fuse after TLR", 4'h8, -1, 0);
        load(4'h2);
        run_action("R6 program", 4'h7, 1, 1);
        run_action("R9 discharge", 4'hA, 1, 1);
        set_addr(3'd1);
        read_col("R11 before fuse", 8'h3C, 1);

        // security fuse
        p0 = c_fuse;
        run_action("R6 fuse", 4'h8, 1, 1);
        check("R11 fuse strobe port", c_fuse - p0, 1);
        run_action("R9 discharge", 4'hA, 1, 1);
        read_col("R11 after fuse", 8'h00, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule